// File: doc/BRIEF.md
# Character Row Sequencer

This block keeps the per-scanline row bookkeeping of a text-mode video controller. Four pieces of state are tracked: a 3-bit row-within-character counter, a 10-bit screen-matrix position counter, a base register that holds the matrix position of the current character row, and a flag that says whether the sequencer is in display state or idle state. The block does not generate cycle or line timing itself. A line timer outside the block supplies the cycle number within the line (1 to 63) and the raster line number. The CPU side supplies a display-enable bit and a 3-bit vertical scroll value, and either one can change on any cycle.

A fetch line is flagged whenever the low three raster bits match the scroll value inside the active window. Because that flag is computed again on every cycle, and the counters only act on it at a few fixed cycles, software can rewrite the scroll value partway through a line. Doing so can skip a character row (crunch), restart the matrix fetch late, or make one character row appear again. The outputs give the counters, the state flag and the live fetch-line flag to the fetch and pixel logic that sits around the block.

Top module: `chrow_seq`

## Requirements
- R1: `badLine` is high exactly when the raster line lies in 0x30..0xF7, the frame is enabled, and `rasterLine[2:0]` equals `yScroll`. The check is made every cycle from the current `yScroll`.
- R2: On cycle 14, `vidCnt` is loaded from the row base. If `badLine` is high on that cycle, `rowCnt` is also cleared to 0.
- R3: While in display state, `vidCnt` increments once on each of cycles 16..55, which is 40 steps per line. On all other cycles except 14 it holds its value.
- R4: On cycle 58, in display state with `rowCnt` below 7, `rowCnt` increments by one.
- R5: On cycle 58, with `rowCnt` equal to 7 and `badLine` low, the sequencer enters idle state (`dispState` = 0), `rowCnt` stays at 7, and the row base takes the value of `vidCnt`.
- R6: If a fetch line is raised after cycle 14 and is still high on cycle 53 while `rowCnt` is 7 in idle state, the sequencer enters display state and `vidCnt` advances 40 from the base. On cycle 58 `rowCnt` wraps to 0 and the base takes the advanced `vidCnt`, so the screen moves on by a character row (crunch).
- R7: If a fetch line is first raised on cycles 54..57 while `rowCnt` is 7 in display state, then on cycle 58 `rowCnt` goes to 0, display state is kept, and the row base is left unchanged. The next line therefore repeats the same character row.
- R8: On any cycle where `badLine` is high, the sequencer is in display state from the next cycle on.
- R9: The frame is enabled only when `denIn` is high during raster line 0x30. If it was low there, no fetch line is flagged in that frame. The enable is cleared on raster line 0.
- R10: After reset, `rowCnt`, `vidCnt` and the row base are 0 and the sequencer is idle. The row base is also cleared on cycle 1 of raster line 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one edge per bus cycle |
| rstN | input | 1 | Active-low synchronous reset |
| cycleIdx | input | 6 | Cycle number within the line, 1..63 |
| rasterLine | input | 9 | Current raster line number |
| denIn | input | 1 | Display enable from the CPU side |
| yScroll | input | 3 | Vertical scroll value from the CPU side |
| rowCnt | output | 3 | Row within the character row |
| vidCnt | output | 10 | Screen-matrix position counter |
| dispState | output | 1 | 1 in display state, 0 in idle state |
| badLine | output | 1 | Live fetch-line condition |

## Verification
The bench rewrites the scroll value at chosen cycles to produce three cases: a normal text screen, a fetch line raised on cycle 15 out of idle, and a fetch line raised on cycle 54 on the last row of a character. A design that treated the late raise the same as the repeat case would send `vidCnt` back to the old base on the following line and lose the crunch. A design that updated the base in the repeat case would move on by 40 when it should show the same row again. A design that failed to go idle on row 7 would wrap `rowCnt` to 0 instead of holding 7. Further checks cover lines outside the window, a frame with display disabled, and a fetch line forced partway through a character row, which must clear `rowCnt` on cycle 14.

// File: rtl/chrow_pkg.sv
package chrow_pkg;
  localparam int CYC_W    = 6;
  localparam int RASTER_W = 9;
  localparam int VC_W     = 10;
  localparam int RC_W     = 3;
  localparam int MATRIX_COLS = 40;

  localparam logic [CYC_W-1:0] CYC_LINE_START  = CYC_W'(1);
  localparam logic [CYC_W-1:0] CYC_VC_LOAD     = CYC_W'(14);
  localparam logic [CYC_W-1:0] CYC_FETCH_FIRST = CYC_W'(16);
  localparam logic [CYC_W-1:0] CYC_FETCH_LAST  = CYC_W'(16 + MATRIX_COLS - 1);
  localparam logic [CYC_W-1:0] CYC_REPEAT_FIRST = CYC_W'(54);
  localparam logic [CYC_W-1:0] CYC_EARLY_SAMPLE = CYC_W'(54 - 1);
  localparam logic [CYC_W-1:0] CYC_ROW_END     = CYC_W'(58);

  localparam logic [RASTER_W-1:0] LINE_FIRST = RASTER_W'(9'h030);
  localparam logic [RASTER_W-1:0] LINE_LAST  = RASTER_W'(9'h0F7);
  localparam logic [RASTER_W-1:0] LINE_TOP   = RASTER_W'(0);

  typedef struct packed {
    logic loadVc;
    logic incVc;
    logic clrRc;
    logic incRc;
    logic latchBase;
    logic clrBase;
  } rowStrobe_t;
endpackage

// File: rtl/chrow_ctrl.sv
module chrow_ctrl
  import chrow_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [CYC_W-1:0]    cycleIdx,
  input  logic [RASTER_W-1:0] rasterLine,
  input  logic                denIn,
  input  logic [RC_W-1:0]     yScroll,
  input  logic                rcIsMax,
  output rowStrobe_t          strobe,
  output logic                dispState,
  output logic                badLine
);
  logic frameEn;
  logic frameEnEff;
  logic inWindow;
  logic dispQ;
  logic badEarly;
  logic atRowEnd;

  assign frameEnEff = frameEn | ((rasterLine == LINE_FIRST) & denIn);
  assign inWindow   = (rasterLine >= LINE_FIRST) && (rasterLine <= LINE_LAST);
  assign badLine    = frameEnEff && inWindow && (rasterLine[RC_W-1:0] == yScroll);
  assign atRowEnd   = (cycleIdx == CYC_ROW_END);
  assign dispState  = dispQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameEn  <= 1'b0;
      dispQ    <= 1'b0;
      badEarly <= 1'b0;
    end else begin
      if (rasterLine == LINE_TOP) frameEn <= 1'b0;
      else if (rasterLine == LINE_FIRST && denIn) frameEn <= 1'b1;

      if (cycleIdx == CYC_EARLY_SAMPLE) badEarly <= badLine;

      if (badLine) dispQ <= 1'b1;
      else if (atRowEnd && rcIsMax) dispQ <= 1'b0;
    end
  end

  always_comb begin
    strobe.loadVc    = (cycleIdx == CYC_VC_LOAD);
    strobe.incVc     = dispQ && (cycleIdx >= CYC_FETCH_FIRST) && (cycleIdx <= CYC_FETCH_LAST);
    strobe.clrRc     = ((cycleIdx == CYC_VC_LOAD) && badLine) || (atRowEnd && rcIsMax && badLine);
    strobe.incRc     = atRowEnd && dispQ && !rcIsMax;
    strobe.latchBase = atRowEnd && rcIsMax && (!badLine || badEarly);
    strobe.clrBase   = (rasterLine == LINE_TOP) && (cycleIdx == CYC_LINE_START);
  end

  // R8: a live fetch line forces display state on the next cycle
  p_disp_follow_r8: assert property (@(posedge clk) disable iff (!rstN)
    badLine |=> dispState);

  // R1: no fetch line outside the active window
  p_bad_window_r1: assert property (@(posedge clk) disable iff (!rstN)
    ((rasterLine < LINE_FIRST) || (rasterLine > LINE_LAST)) |-> !badLine);

  // R5: row 7 with no fetch line ends in idle
  p_idle_entry_r5: assert property (@(posedge clk) disable iff (!rstN)
    (atRowEnd && rcIsMax && !badLine) |=> !dispState);
endmodule

// File: rtl/chrow_datapath.sv
module chrow_datapath
  import chrow_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  rowStrobe_t       strobe,
  output logic [RC_W-1:0]  rowCnt,
  output logic [VC_W-1:0]  vidCnt,
  output logic             rcIsMax
);
  logic [VC_W-1:0] vcBase;

  assign rcIsMax = &rowCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowCnt <= '0;
      vidCnt <= '0;
      vcBase <= '0;
    end else begin
      if (strobe.clrRc) rowCnt <= '0;
      else if (strobe.incRc) rowCnt <= rowCnt + RC_W'(1);

      if (strobe.loadVc) vidCnt <= vcBase;
      else if (strobe.incVc) vidCnt <= vidCnt + VC_W'(1);

      if (strobe.clrBase) vcBase <= '0;
      else if (strobe.latchBase) vcBase <= vidCnt;
    end
  end

  // R3: the counter only moves on its load or step strobes
  p_vc_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.loadVc && !strobe.incVc) |=> $stable(vidCnt));
endmodule

// File: rtl/chrow_seq.sv
module chrow_seq
  import chrow_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [CYC_W-1:0]    cycleIdx,
  input  logic [RASTER_W-1:0] rasterLine,
  input  logic                denIn,
  input  logic [RC_W-1:0]     yScroll,
  output logic [RC_W-1:0]     rowCnt,
  output logic [VC_W-1:0]     vidCnt,
  output logic                dispState,
  output logic                badLine
);
  rowStrobe_t strobe;
  logic       rcIsMax;

  chrow_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cycleIdx   (cycleIdx),
    .rasterLine (rasterLine),
    .denIn      (denIn),
    .yScroll    (yScroll),
    .rcIsMax    (rcIsMax),
    .strobe     (strobe),
    .dispState  (dispState),
    .badLine    (badLine)
  );

  chrow_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .rowCnt  (rowCnt),
    .vidCnt  (vidCnt),
    .rcIsMax (rcIsMax)
  );

  // R2: a fetch line on cycle 14 clears the row counter
  p_rc_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cycleIdx == CYC_VC_LOAD && badLine) |=> (rowCnt == '0));

  // R4: display rows below 7 step by one at the row end
  p_rc_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cycleIdx == CYC_ROW_END && dispState && rowCnt != '1)
      |=> (rowCnt == $past(rowCnt) + RC_W'(1)));

  // R5: idle entry keeps the row counter at 7
  p_rc_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cycleIdx == CYC_ROW_END && rowCnt == '1 && !badLine) |=> (rowCnt == '1));
endmodule

// File: tb/chrow_seq_tb.sv
module chrow_seq_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] cycCnt = 6'd1;
  logic [8:0] lineCnt = 9'd0;
  logic       denIn = 1'b1;
  logic [2:0] yScroll = 3'd3;
  logic [2:0] rowCnt;
  logic [9:0] vidCnt;
  logic       dispState;
  logic       badLine;

  int checks = 0;
  int fails = 0;
  int ticks = 0;

  always #2.5 clk = ~clk;

  chrow_seq u_dut (
    .clk(clk), .rstN(rstN), .cycleIdx(cycCnt), .rasterLine(lineCnt),
    .denIn(denIn), .yScroll(yScroll),
    .rowCnt(rowCnt), .vidCnt(vidCnt), .dispState(dispState), .badLine(badLine)
  );

  // line timer: 63 cycles per line, 312 lines per frame
  always @(posedge clk) begin
    ticks <= ticks + 1;
    if (rstN) begin
      if (cycCnt == 6'd63) begin
        cycCnt  <= 6'd1;
        lineCnt <= (lineCnt == 9'd311) ? 9'd0 : lineCnt + 9'd1;
      end else begin
        cycCnt <= cycCnt + 6'd1;
      end
    end
  end

  always @(posedge clk) begin
    if (ticks > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset(input logic den, input logic [2:0] ys);
    @(negedge clk);
    rstN = 1'b0;
    denIn = den;
    yScroll = ys;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  // stops at the negedge during cycle c of line l; state shows the end of cycle c-1
  task automatic gotoCycle(input int l, input int c);
    while (!(int'(lineCnt) == l && int'(cycCnt) == c)) @(negedge clk);
  endtask

  task automatic testReset();
    doReset(1'b1, 3'd3);
    check("R10 rowCnt after reset", rowCnt, 0);
    check("R10 vidCnt after reset", vidCnt, 0);
    check("R10 idle after reset", dispState, 0);
    check("R10 badLine after reset", badLine, 0);
  endtask

  task automatic testNormal();
    doReset(1'b1, 3'd3);
    gotoCycle(9'h033, 15);
    check("R1 badLine on matching line", badLine, 1);
    check("R2 rowCnt cleared at cycle 14", rowCnt, 0);
    check("R8 display on fetch line", dispState, 1);
    check("R2 vidCnt loaded from base", vidCnt, 0);
    gotoCycle(9'h033, 36);
    check("R3 vidCnt mid-line", vidCnt, 20);
    gotoCycle(9'h033, 57);
    check("R3 vidCnt after 40 steps", vidCnt, 40);
    gotoCycle(9'h033, 62);
    check("R3 vidCnt holds after window", vidCnt, 40);
    check("R4 rowCnt stepped", rowCnt, 1);
    gotoCycle(9'h034, 15);
    check("R2 vidCnt reloaded on next line", vidCnt, 0);
    gotoCycle(9'h03A, 20);
    check("R1 badLine low on non-matching line", badLine, 0);
    gotoCycle(9'h03A, 60);
    check("R5 idle after row 7", dispState, 0);
    check("R5 rowCnt holds at 7", rowCnt, 7);
    gotoCycle(9'h03B, 15);
    check("R5 base advanced to next row", vidCnt, 40);
    check("R2 rowCnt cleared on new row", rowCnt, 0);
    gotoCycle(9'h03B, 57);
    check("R3 second row end", vidCnt, 80);
    gotoCycle(9'h0F3, 20);
    check("R1 badLine near window end", badLine, 1);
    gotoCycle(9'h0FB, 20);
    check("R1 badLine past window", badLine, 0);
  endtask

  task automatic testCrunch();
    doReset(1'b1, 3'd3);
    gotoCycle(9'h03A, 60);
    yScroll = 3'd4;
    gotoCycle(9'h03B, 15);
    check("R6 idle before late raise", dispState, 0);
    check("R6 vidCnt loaded from base", vidCnt, 40);
    yScroll = 3'd3;
    gotoCycle(9'h03B, 17);
    check("R8 display after late raise", dispState, 1);
    check("R6 rowCnt still 7", rowCnt, 7);
    gotoCycle(9'h03B, 57);
    check("R6 vidCnt advanced by 40", vidCnt, 80);
    gotoCycle(9'h03B, 60);
    check("R6 rowCnt wrapped to 0", rowCnt, 0);
    check("R6 display kept", dispState, 1);
    gotoCycle(9'h03C, 15);
    check("R6 base took advanced vidCnt", vidCnt, 80);
    gotoCycle(9'h03C, 60);
    check("R4 rowCnt after crunch", rowCnt, 1);
  endtask

  task automatic testRepeat();
    doReset(1'b1, 3'd3);
    gotoCycle(9'h03A, 54);
    check("R7 display on row 7", dispState, 1);
    check("R7 rowCnt is 7", rowCnt, 7);
    yScroll = 3'd2;
    gotoCycle(9'h03A, 60);
    check("R7 rowCnt restarts at 0", rowCnt, 0);
    check("R7 display kept", dispState, 1);
    gotoCycle(9'h03B, 15);
    check("R7 same row repeated", vidCnt, 0);
    gotoCycle(9'h03B, 57);
    check("R7 repeated row steps 40", vidCnt, 40);
    gotoCycle(9'h03B, 60);
    check("R4 rowCnt after repeat", rowCnt, 1);
  endtask

  task automatic testMidRow();
    doReset(1'b1, 3'd3);
    gotoCycle(9'h035, 5);
    check("R4 rowCnt before forced fetch", rowCnt, 2);
    yScroll = 3'd5;
    gotoCycle(9'h035, 15);
    check("R2 forced fetch clears rowCnt", rowCnt, 0);
    check("R2 vidCnt reloaded", vidCnt, 0);
  endtask

  task automatic testDisabled();
    doReset(1'b0, 3'd3);
    gotoCycle(9'h033, 20);
    check("R9 no fetch line when disabled", badLine, 0);
    check("R9 stays idle when disabled", dispState, 0);
    gotoCycle(9'h034, 5);
    denIn = 1'b1;
    gotoCycle(9'h03B, 20);
    check("R9 late enable ignored", badLine, 0);
  endtask

  initial begin
    testReset();
    testNormal();
    testCrunch();
    testRepeat();
    testMidRow();
    testDisabled();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule